// File: doc/BRIEF.md
# Gain Amplifier and Dual-Channel ADC Serial Sequencer

This block is the serial master for a programmable-gain amplifier and a two-channel sampling ADC that hang off one shared serial clock. After reset it writes an 8-bit gain word to the amplifier, framed by an active-low select. It then runs conversion frames back to back. Each frame starts with a high convert strobe that makes the ADC sample both channels at once, followed by 36 serial clocks that read two 14-bit two's-complement results. Each result field has a two-clock high-impedance gap before it and after it.

The ADC returns the result of the previous convert strobe, so each reported pair is one conversion old. The very first pair after reset holds no real sample and is dropped. A pulse on the gain load input requests a new gain write. That write is placed between two conversion frames, and no frame runs while it is in progress. The serial clock runs at half the system clock. The amplifier shutdown line and the selects of the other devices on the bus are held inactive.

Top module: `pga_adc_sequencer`

## Requirements
- R1: While reset is asserted and during the first system cycle after release, amp_cs_no is 1, conv_o is 0, sck_o is 0 and valid_o is 0.
- R2: After reset, one gain write is made. amp_cs_no goes low for exactly 8 SCK periods, and gain_i is sent on mosi_o MSB first. Each bit is stable while SCK is high, and the slave samples it on the rising SCK edge. The word is committed when amp_cs_no rises.
- R3: A one-cycle pulse on gain_load_i causes one more gain write, carrying the value gain_i has when that write starts. The write is placed after the current frame and its idle gap. conv_o is never high while amp_cs_no is low.
- R4: Each frame starts with conv_o high for exactly 2 system cycles while SCK is low. Exactly 36 SCK periods follow.
- R5: In steady running, conv_o rises every 80 system cycles (625 kHz at a 50 MHz system clock). Across a gain write the spacing is 102 cycles. It is never less than 34 cycles (about 1.5 MHz).
- R6: SCK periods in a frame are numbered k = 0 to 35 after the convert strobe. Channel 0 is taken from k = 2 to 15 and channel 1 from k = 20 to 33, MSB first, each bit sampled on the rising SCK edge. The gap bits (k = 0, 1, 16 to 19, 34, 35) have no effect on the results.
- R7: The 14-bit fields are reported on ch0_o and ch1_o bit for bit, with two's-complement extremes 0x1FFF and 0x2000 included. The pair reported after frame n+1 is the data the ADC shifted out in that frame, which is the sample taken at convert strobe n.
- R8: valid_o pulses for one cycle, 74 cycles after conv_o rises. The pair read in the first frame after reset is dropped with no valid_o pulse. ch0_o and ch1_o hold their values between pulses.
- R9: amp_shdn_o is always 0, and every bit of other_cs_no is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock (50 MHz) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| gain_i | input | 8 | Gain word to write to the amplifier |
| gain_load_i | input | 1 | Pulse that requests a new gain write |
| miso_i | input | 1 | Serial data from the ADC |
| sck_o | output | 1 | Shared serial clock, idle low |
| mosi_o | output | 1 | Serial data to the amplifier |
| amp_cs_no | output | 1 | Amplifier select, active low |
| amp_shdn_o | output | 1 | Amplifier shutdown, held low |
| conv_o | output | 1 | ADC convert strobe, active high |
| other_cs_no | output | 3 | Selects of other bus devices, held high |
| ch0_o | output | 14 | Channel 0 result, two's complement |
| ch1_o | output | 14 | Channel 1 result, two's complement |
| valid_o | output | 1 | One-cycle strobe marking a new result pair |

## Verification
Once conv_o rises, each result pair is due 74 system cycles later: 2 convert cycles, 72 cycles of serial clock, and one output register. The next convert strobe is due 80 cycles after the previous one, or 102 cycles when a gain write comes in between. Each gain bit can be read one half-cycle after the SCK rise that samples it. The bench drives inputs and samples outputs on the falling system-clock edge. It counts cycles from each convert rise, so every check is made on the exact cycle those counts name. Its ADC model returns each table vector one frame late and drives 1 in every gap bit, so a wrongly placed field or a lost latency step gives a wrong pair.

// File: rtl/pas_pkg.sv
package pas_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_GAIN,
    ST_CONV,
    ST_FRAME
  } seq_st_e;
endpackage

// File: rtl/pas_seq.sv
module pas_seq
  import pas_pkg::*;
#(
  parameter int GAIN_SYS  = 16,
  parameter int FRAME_SYS = 72,
  parameter int CONV_CYC  = 2,
  parameter int IDLE_CYC  = 6,
  parameter int CNT_W     = 7,
  parameter int IDX_W     = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_req_i,
  output logic             sck_o,
  output logic             amp_cs_no,
  output logic             conv_o,
  output logic             start_gain_o,
  output logic             shift_o,
  output logic             cap_o,
  output logic             frame_done_o,
  output logic [IDX_W-1:0] bit_idx_o
);
  seq_st_e          st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;
  logic             idle_end, gain_end, conv_end;

  assign idle_end     = (st_q == ST_IDLE)  && (cnt_q == CNT_W'(IDLE_CYC - 1));
  assign gain_end     = (st_q == ST_GAIN)  && (cnt_q == CNT_W'(GAIN_SYS - 1));
  assign conv_end     = (st_q == ST_CONV)  && (cnt_q == CNT_W'(CONV_CYC - 1));
  assign frame_done_o = (st_q == ST_FRAME) && (cnt_q == CNT_W'(FRAME_SYS - 1));
  assign start_gain_o = idle_end && pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      pend_q <= 1'b1;
    end else begin
      pend_q <= load_req_i | (pend_q & ~start_gain_o);
      if (idle_end) begin
        st_q  <= pend_q ? ST_GAIN : ST_CONV;
        cnt_q <= '0;
      end else if (gain_end || frame_done_o) begin
        st_q  <= ST_IDLE;
        cnt_q <= '0;
      end else if (conv_end) begin
        st_q  <= ST_FRAME;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // odd count = SCK high half
  assign sck_o     = ((st_q == ST_GAIN) || (st_q == ST_FRAME)) && cnt_q[0];
  assign amp_cs_no = (st_q != ST_GAIN);
  assign conv_o    = (st_q == ST_CONV);
  assign shift_o   = (st_q == ST_GAIN) && cnt_q[0];
  assign cap_o     = (st_q == ST_FRAME) && !cnt_q[0];
  assign bit_idx_o = cnt_q[CNT_W-1:1];
endmodule

// File: rtl/pas_gain_tx.sv
module pas_gain_tx #(
  parameter int GAIN_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic              start_i,
  input  logic              shift_i,
  input  logic              active_i,
  output logic              mosi_o
);
  logic [GAIN_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (start_i) sr_q <= gain_i;
    else if (shift_i) sr_q <= {sr_q[GAIN_W-2:0], 1'b0};
  end

  assign mosi_o = active_i & sr_q[GAIN_W-1];
endmodule

// File: rtl/pas_rx.sv
module pas_rx #(
  parameter int DATA_W = 14,
  parameter int GAP    = 2,
  parameter int NUM_CH = 2,
  parameter int IDX_W  = 6
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           miso_i,
  input  logic                           cap_i,
  input  logic [IDX_W-1:0]               bit_idx_i,
  input  logic                           frame_done_i,
  output logic [NUM_CH-1:0][DATA_W-1:0]  res_o,
  output logic                           valid_o
);
  localparam int FIELD_SPAN = DATA_W + 2 * GAP;

  logic first_q, valid_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [IDX_W-1:0] LO = IDX_W'(GAP + c * FIELD_SPAN);
    localparam logic [IDX_W-1:0] HI = IDX_W'(GAP + c * FIELD_SPAN + DATA_W - 1);
    logic [DATA_W-1:0] sh_q, res_q;
    logic              in_field;

    assign in_field = (bit_idx_i >= LO) && (bit_idx_i <= HI);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_q  <= '0;
        res_q <= '0;
      end else begin
        if (cap_i && in_field) sh_q <= {sh_q[DATA_W-2:0], miso_i};
        if (frame_done_i)      res_q <= sh_q;
      end
    end

    assign res_o[c] = res_q;
  end

  // first frame carries no real sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= 1'b1;
      valid_q <= 1'b0;
    end else begin
      valid_q <= frame_done_i & ~first_q;
      if (frame_done_i) first_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
endmodule

// File: rtl/pga_adc_sequencer.sv
module pga_adc_sequencer #(
  parameter int GAIN_W       = 8,
  parameter int DATA_W       = 14,
  parameter int GAP_SCK      = 2,
  parameter int CONV_CYC     = 2,
  parameter int FRAME_CYCLES = 80,
  parameter int SYS_HZ       = 50_000_000,
  parameter int MAX_CONV_HZ  = 1_500_000,
  parameter int N_OTHER      = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [GAIN_W-1:0]  gain_i,
  input  logic               gain_load_i,
  input  logic               miso_i,
  output logic               sck_o,
  output logic               mosi_o,
  output logic               amp_cs_no,
  output logic               amp_shdn_o,
  output logic               conv_o,
  output logic [N_OTHER-1:0] other_cs_no,
  output logic [DATA_W-1:0]  ch0_o,
  output logic [DATA_W-1:0]  ch1_o,
  output logic               valid_o
);
  localparam int NUM_CH       = 2;
  localparam int FRAME_SCK    = NUM_CH * (DATA_W + 2 * GAP_SCK);
  localparam int GAIN_SYS     = 2 * GAIN_W;
  localparam int FRAME_SYS    = 2 * FRAME_SCK;
  localparam int IDLE_CYC     = FRAME_CYCLES - CONV_CYC - FRAME_SYS;
  localparam int MAX_A        = (FRAME_SYS > GAIN_SYS) ? FRAME_SYS : GAIN_SYS;
  localparam int MAX_B        = (IDLE_CYC > CONV_CYC) ? IDLE_CYC : CONV_CYC;
  localparam int MAX_LEN      = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W        = $clog2(MAX_LEN);
  localparam int IDX_W        = CNT_W - 1;
  localparam int MIN_CONV_GAP = (SYS_HZ + MAX_CONV_HZ - 1) / MAX_CONV_HZ;

  logic                          start_gain, shift, cap, frame_done;
  logic [IDX_W-1:0]              bit_idx;
  logic [NUM_CH-1:0][DATA_W-1:0] res;

  pas_seq #(
    .GAIN_SYS (GAIN_SYS),
    .FRAME_SYS(FRAME_SYS),
    .CONV_CYC (CONV_CYC),
    .IDLE_CYC (IDLE_CYC),
    .CNT_W    (CNT_W),
    .IDX_W    (IDX_W)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_req_i  (gain_load_i),
    .sck_o       (sck_o),
    .amp_cs_no   (amp_cs_no),
    .conv_o      (conv_o),
    .start_gain_o(start_gain),
    .shift_o     (shift),
    .cap_o       (cap),
    .frame_done_o(frame_done),
    .bit_idx_o   (bit_idx)
  );

  pas_gain_tx #(.GAIN_W(GAIN_W)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .gain_i  (gain_i),
    .start_i (start_gain),
    .shift_i (shift),
    .active_i(!amp_cs_no),
    .mosi_o  (mosi_o)
  );

  pas_rx #(
    .DATA_W(DATA_W),
    .GAP   (GAP_SCK),
    .NUM_CH(NUM_CH),
    .IDX_W (IDX_W)
  ) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .miso_i      (miso_i),
    .cap_i       (cap),
    .bit_idx_i   (bit_idx),
    .frame_done_i(frame_done),
    .res_o       (res),
    .valid_o     (valid_o)
  );

  assign ch0_o       = res[0];
  assign ch1_o       = res[1];
  assign amp_shdn_o  = 1'b0;
  assign other_cs_no = '1;
endmodule

// File: rtl/pas_chk.sv
module pas_chk #(
  parameter int GAIN_W       = 8,
  parameter int FRAME_SCK    = 36,
  parameter int MIN_CONV_GAP = 34
) (
  input logic clk_i,
  input logic rst_ni,
  input logic amp_cs_no,
  input logic sck_o,
  input logic mosi_o,
  input logic conv_o,
  input logic valid_o
);
  localparam int GB_W = $clog2(GAIN_W + 1);
  localparam int FR_W = $clog2(FRAME_SCK + 1);
  localparam int GP_W = $clog2(MIN_CONV_GAP + 1);

  logic            sck_q, cs_q, conv_q;
  logic [GB_W-1:0] gbits_q;
  logic [FR_W-1:0] frises_q;
  logic [GP_W-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q    <= 1'b0;
      cs_q     <= 1'b1;
      conv_q   <= 1'b0;
      gbits_q  <= '0;
      frises_q <= '0;
      gap_q    <= GP_W'(MIN_CONV_GAP);
    end else begin
      sck_q  <= sck_o;
      cs_q   <= amp_cs_no;
      conv_q <= conv_o;
      if (amp_cs_no)                gbits_q <= '0;
      else if (sck_o && !sck_q)     gbits_q <= gbits_q + 1'b1;
      if (conv_o)                   frises_q <= '0;
      else if (amp_cs_no && sck_o && !sck_q) frises_q <= frises_q + 1'b1;
      if (conv_o && !conv_q)        gap_q <= GP_W'(1);
      else if (gap_q != GP_W'(MIN_CONV_GAP)) gap_q <= gap_q + 1'b1;
    end
  end

  // R2
  gain_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (amp_cs_no && !cs_q) |-> (gbits_q == GB_W'(GAIN_W)));
  // R2
  mosi_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!amp_cs_no && sck_o) |-> $stable(mosi_o));
  // R3
  conv_outside_gain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_o |-> amp_cs_no);
  // R4
  conv_sck_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_o |-> !sck_o);
  // R4
  frame_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (frises_q == FR_W'(FRAME_SCK)));
  // R5
  conv_rate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_o && !conv_q) |-> (gap_q == GP_W'(MIN_CONV_GAP)));
  // R8
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

bind pga_adc_sequencer pas_chk #(
  .GAIN_W      (GAIN_W),
  .FRAME_SCK   (FRAME_SCK),
  .MIN_CONV_GAP(MIN_CONV_GAP)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .amp_cs_no(amp_cs_no),
  .sck_o    (sck_o),
  .mosi_o   (mosi_o),
  .conv_o   (conv_o),
  .valid_o  (valid_o)
);

// File: tb/pga_adc_sequencer_test.sv
module pga_adc_sequencer_test;
  localparam int CLK_PERIOD   = 20;
  localparam int NVEC         = 8;
  localparam int CONV_SPACING = 80;
  localparam int GAIN_SPACING = 102;
  localparam int VALID_DELAY  = 74;
  localparam logic [27:0] VEC [NVEC] = '{
    {14'h0000, 14'h3FFF},
    {14'h1FFF, 14'h2000},
    {14'h2000, 14'h1FFF},
    {14'h0001, 14'h3FFE},
    {14'h2AAA, 14'h1555},
    {14'h1234, 14'h2F0F},
    {14'h3FFF, 14'h0000},
    {14'h0C3A, 14'h33C5}
  };
  localparam logic [27:0] STALE = {14'h1555, 14'h2AAA};

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  gain = 8'hA7, exp_gain = 8'hA7;
  logic        gain_load = 1'b0, miso = 1'b0;
  logic        sck, mosi, cs_n, shdn, conv, valid;
  logic [2:0]  other_cs_n;
  logic [13:0] ch0, ch1;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  pga_adc_sequencer uut (
    .clk_i(clk), .rst_ni(rst_n), .gain_i(gain), .gain_load_i(gain_load),
    .miso_i(miso), .sck_o(sck), .mosi_o(mosi), .amp_cs_no(cs_n),
    .amp_shdn_o(shdn), .conv_o(conv), .other_cs_no(other_cs_n),
    .ch0_o(ch0), .ch1_o(ch1), .valid_o(valid)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor and ADC model
  int          cyc = 0, conv_cnt = 0, last_conv = 0, conv_hi = 0, vcnt = 0;
  int          k = 40, gbits = 0, gain_writes = 0;
  int          conv_in_gain = 0, static_bad = 0, hold_bad = 0;
  bit          gain_between = 1'b0;
  logic        p_sck = 1'b0, p_cs = 1'b1, p_conv = 1'b0, p_valid = 1'b0;
  logic [7:0]  gword = '0;
  logic [27:0] word = '0, held = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (shdn !== 1'b0 || other_cs_n !== 3'b111) static_bad++;
      if (conv && !cs_n) conv_in_gain++;
      if (!cs_n && sck && !p_sck) begin
        gword = {gword[6:0], mosi};
        gbits++;
      end
      if (cs_n && !p_cs) begin
        chk(gword == exp_gain, "R2 gain word", 32'(gword), 32'(exp_gain));
        chk(gbits == 8, "R2 gain bit count", 32'(gbits), 32'd8);
        gbits = 0;
        gain_writes++;
        gain_between = 1'b1;
      end
      if (conv) conv_hi++;
      if (!conv && p_conv) begin
        chk(conv_hi == 2, "R4 convert width", 32'(conv_hi), 32'd2);
        conv_hi = 0;
      end
      if (conv && !p_conv) begin
        conv_cnt++;
        if (conv_cnt > 1) begin
          if (gain_between)
            chk(cyc - last_conv == GAIN_SPACING, "R5 spacing across gain write",
                32'(cyc - last_conv), 32'(GAIN_SPACING));
          else
            chk(cyc - last_conv == CONV_SPACING, "R5 convert spacing",
                32'(cyc - last_conv), 32'(CONV_SPACING));
        end
        gain_between = 1'b0;
        last_conv = cyc;
        k = 0;
        word = (conv_cnt == 1) ? STALE : VEC[(conv_cnt - 2) % NVEC];
      end else if (cs_n && !sck && p_sck) begin
        k++;
      end
      // R6 field placement, gaps driven to 1
      if (k >= 2 && k <= 15)       miso = word[27 - (k - 2)];
      else if (k >= 20 && k <= 33) miso = word[13 - (k - 20)];
      else                         miso = 1'b1;
      if (valid) begin
        chk(cyc - last_conv == VALID_DELAY, "R8 valid latency",
            32'(cyc - last_conv), 32'(VALID_DELAY));
        chk(conv_cnt == vcnt + 2, "R8 first pair dropped", 32'(conv_cnt),
            32'(vcnt + 2));
        if (p_valid) chk(1'b0, "R8 valid width", 32'd2, 32'd1);
        held = {ch0, ch1};
        vcnt++;
      end else if (vcnt > 0 && {ch0, ch1} != held) begin
        hold_bad++;
      end
      p_sck = sck; p_cs = cs_n; p_conv = conv; p_valid = valid;
    end
  end

  task automatic wait_valid();
    @(negedge clk);
    while (!valid) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1, "R1 cs in reset", 32'(cs_n), 32'd1);
    chk({conv, sck, valid} == 3'b000, "R1 conv/sck/valid in reset",
        32'({conv, sck, valid}), 32'd0);
    chk(shdn == 1'b0 && other_cs_n == 3'b111, "R9 static lines in reset",
        32'({shdn, other_cs_n}), 32'h7);
    rst_n = 1'b1;
    @(negedge clk);
    chk({cs_n, conv, sck, valid} == 4'b1000, "R1 state after release",
        32'({cs_n, conv, sck, valid}), 32'h8);

    for (int j = 0; j < NVEC; j++) begin
      wait_valid();
      chk(ch0 == VEC[j][27:14], "R6 R7 channel 0 result", 32'(ch0), 32'(VEC[j][27:14]));
      chk(ch1 == VEC[j][13:0], "R6 R7 channel 1 result", 32'(ch1), 32'(VEC[j][13:0]));
    end
    chk(gain_writes == 1, "R2 single write after reset", 32'(gain_writes), 32'd1);

    // R3 gain reload mid-run
    @(negedge clk);
    gain = 8'h5C;
    exp_gain = 8'h5C;
    gain_load = 1'b1;
    @(negedge clk);
    gain_load = 1'b0;
    for (int j = NVEC; j < NVEC + 3; j++) begin
      wait_valid();
      chk(ch0 == VEC[j % NVEC][27:14], "R3 R7 channel 0 after reload",
          32'(ch0), 32'(VEC[j % NVEC][27:14]));
      chk(ch1 == VEC[j % NVEC][13:0], "R3 R7 channel 1 after reload",
          32'(ch1), 32'(VEC[j % NVEC][13:0]));
    end
    chk(gain_writes == 2, "R3 reload write count", 32'(gain_writes), 32'd2);
    chk(conv_in_gain == 0, "R3 convert during gain write", 32'(conv_in_gain), 32'd0);
    chk(static_bad == 0, "R9 shutdown and other selects", 32'(static_bad), 32'd0);
    chk(hold_bad == 0, "R8 results held between strobes", 32'(hold_bad), 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", vcnt, NVEC + 3);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule